// File: doc/BRIEF.md
# Rotate Unit with Carry and Overflow Flags

This block rotates an 8, 16 or 32-bit operand. It supports three operations: rotate left, rotate right, and rotate right through the incoming carry. It returns the rotated value together with new carry and overflow flags. It also returns a flags-valid bit. When that bit is low, the consumer must leave its carry and overflow state as it was.

The rotate count is reduced to the operand width. For rotate left and rotate right the count is masked. For rotate through carry it is taken modulo the width plus one. For the two narrow sizes, a masked count of zero still updates the flags if the higher count bits are set. For all right rotates, overflow is formed from the top two result bits at every count, not only at a count of one.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, with one register stage in between.
- A request is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A result holds steady while `out_valid` is high and `out_ready` is low.
- A result appears on the outputs one cycle after its request is accepted.

Top module: `rotflag_unit`

## Requirements
- R1: `in_size` encodes the operand width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 is treated as 32 bits. Only the low width bits of `in_operand` are used. `out_result` is zero-extended above the operand width.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs hold their values. A result appears one cycle after acceptance, and `out_valid` falls after a drain if no new request is accepted.
- R3: `in_op` = 0 is rotate left by the count masked to the width (low 3, 4 or 5 bits). When flags update, carry equals result bit 0 and overflow equals result bit 0 XOR the result MSB.
- R4: `in_op` = 1 is rotate right by the masked count. When flags update, carry equals the result MSB and overflow equals the result MSB XOR the next lower result bit, for any count.
- R5: `in_op` = 2 is rotate right through carry by the count modulo (width+1); the modulus is 9, 17 or 33. A reduced count of zero returns the operand with flags-valid low. Otherwise carry equals operand bit (reduced count − 1), overflow equals result MSB XOR result MSB−1, and flags-valid is high.
- R6: For rotate left and rotate right, flags-valid is high when the masked count is nonzero. With a masked count of zero:
  - an 8-bit rotate left updates flags if count bit 3 or bit 4 is set;
  - an 8-bit rotate right, and either 16-bit rotate, updates flags only if count bit 4 is set;
  - a 32-bit rotate by zero never updates flags.
- R7: `in_op` = 3 passes the operand through unchanged, with flags-valid low.
- R8: Whenever flags-valid is low, `out_carry` equals the request's `in_carry` and `out_overflow` is 0.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_operand | input | 32 | Operand, low bits used for narrow sizes |
| in_count | input | 5 | Rotate count |
| in_op | input | 2 | Operation select |
| in_size | input | 2 | Operand width select |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Rotated value, zero-extended |
| out_carry | output | 1 | New carry flag |
| out_overflow | output | 1 | New overflow flag |
| out_flags_valid | output | 1 | Flags must be written when high |

## Verification
The bench sweeps every size, operation, count and carry-in over a set of operands whose upper bits are set, and checks against a bit-by-bit model.

That sweep targets the following errors:
- **Raw count used as the rotate amount:** a design that rotated by the raw count instead of the masked count would give wrong results at counts of 8 and above.
- **Flags dropped at masked-zero counts:** a design that skipped the flag update whenever the masked count was zero would drop flags at counts 8, 16 and 24.
- **Byte rotate right updated on bit 3:** a design that made byte rotate right update on count bit 3 would raise flags-valid at count 8.
- **Right-rotate overflow taken from the operand:** a design that took right-rotate overflow from operand XOR result would disagree at counts other than one.
- **Wrong through-carry modulus:** a design that reduced the through-carry count modulo the width would mis-rotate at counts 9 and 17.

A stall test holds `out_ready` low while a second request waits. It catches a design that overwrites a held result or raises `in_ready` early.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    RF_ROL  = 2'd0,
    RF_ROR  = 2'd1,
    RF_RCR  = 2'd2,
    RF_PASS = 2'd3
  } rf_op_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/rf_lane.sv
module rf_lane
  import rf_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     opnd,
  input  logic [CNT_W-1:0] cnt,
  input  rf_op_e           op,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cf,
  output logic             of,
  output logic             upd
);
  localparam int LW = $clog2(W);
  localparam logic [CNT_W:0] MODV = (CNT_W+1)'(W + 1);

  logic [LW-1:0]    rc;
  logic [CNT_W:0]   rr;
  logic [2*W-1:0]   dl, dr;
  logic [W:0]       ext;
  logic [2*W+1:0]   de;
  logic [W:0]       rcr;
  logic             hi_any, hi_top;

  assign rc  = cnt[LW-1:0];
  assign rr  = {1'b0, cnt} % MODV;
  assign dl  = {opnd, opnd} << rc;
  assign dr  = {opnd, opnd} >> rc;
  assign ext = {cin, opnd};
  assign de  = {ext, ext} >> rr;
  assign rcr = de[W:0];

  generate
    if (LW < CNT_W) begin : g_hi
      assign hi_any = |cnt[CNT_W-1:LW];
      assign hi_top = cnt[CNT_W-1];
    end else begin : g_nohi
      assign hi_any = 1'b0;
      assign hi_top = 1'b0;
    end
  endgenerate

  always_comb begin
    res = opnd;
    cf  = 1'b0;
    of  = 1'b0;
    upd = 1'b0;
    unique case (op)
      RF_ROL: begin
        res = dl[2*W-1:W];
        cf  = res[0];
        of  = res[0] ^ res[W-1];
        upd = (rc != '0) || hi_any;
      end
      RF_ROR: begin
        res = dr[W-1:0];
        cf  = res[W-1];
        of  = res[W-1] ^ res[W-2];
        upd = (rc != '0) || hi_top;
      end
      RF_RCR: begin
        res = rcr[W-1:0];
        cf  = rcr[W];
        of  = rcr[W-1] ^ rcr[W-2];
        upd = (rr != '0);
      end
      default: begin
        res = opnd;
        upd = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rf_select.sv
module rf_select
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NUM_SIZES-1:0][DATA_W-1:0] res_all,
  input  logic [NUM_SIZES-1:0]             cf_all,
  input  logic [NUM_SIZES-1:0]             of_all,
  input  logic [NUM_SIZES-1:0]             upd_all,
  input  logic [1:0]                       size,
  input  logic                             cin,
  output logic [DATA_W-1:0]                res,
  output logic                             cf,
  output logic                             of,
  output logic                             fv
);
  localparam logic [1:0] LAST = 2'(NUM_SIZES - 1);

  logic [1:0] sel;

  assign sel = (size > LAST) ? LAST : size;

  always_comb begin
    res = res_all[sel];
    fv  = upd_all[sel];
    cf  = fv ? cf_all[sel] : cin;
    of  = fv ? of_all[sel] : 1'b0;
  end
endmodule

// File: rtl/rotflag_unit.sv
module rotflag_unit
  import rf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_operand,
  input  logic [4:0]  in_count,
  input  logic [1:0]  in_op,
  input  logic [1:0]  in_size,
  input  logic        in_carry,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_result,
  output logic        out_carry,
  output logic        out_overflow,
  output logic        out_flags_valid
);
  localparam int DATA_W = BYTE_W << (NUM_SIZES - 1);
  localparam int CNT_W  = $clog2(DATA_W);

  logic [NUM_SIZES-1:0][DATA_W-1:0] res_all;
  logic [NUM_SIZES-1:0]             cf_all, of_all, upd_all;
  logic [DATA_W-1:0]                nx_res;
  logic                             nx_cf, nx_of, nx_fv;
  logic                             acc;
  rf_op_e                           op_e;

  assign op_e     = rf_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  generate
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
      localparam int LANE_W = BYTE_W << g;
      logic [LANE_W-1:0] lane_res;
      rf_lane #(.W(LANE_W), .CNT_W(CNT_W)) u_lane (
        .opnd (in_operand[LANE_W-1:0]),
        .cnt  (in_count),
        .op   (op_e),
        .cin  (in_carry),
        .res  (lane_res),
        .cf   (cf_all[g]),
        .of   (of_all[g]),
        .upd  (upd_all[g])
      );
      assign res_all[g] = DATA_W'(lane_res);
    end
  endgenerate

  rf_select #(.DATA_W(DATA_W)) u_sel (
    .res_all (res_all),
    .cf_all  (cf_all),
    .of_all  (of_all),
    .upd_all (upd_all),
    .size    (in_size),
    .cin     (in_carry),
    .res     (nx_res),
    .cf      (nx_cf),
    .of      (nx_of),
    .fv      (nx_fv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_carry       <= 1'b0;
      out_overflow    <= 1'b0;
      out_flags_valid <= 1'b0;
    end else begin
      if (acc) begin
        out_valid       <= 1'b1;
        out_result      <= nx_res;
        out_carry       <= nx_cf;
        out_overflow    <= nx_of;
        out_flags_valid <= nx_fv;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_carry) && $stable(out_flags_valid)); // R2
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    acc && in_size == 2'd0 |=> out_result[DATA_W-1:BYTE_W] == '0); // R1
  AST_ROL_BYTE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    acc && in_size == 2'd0 && in_op == 2'd0 |=> !out_flags_valid ||
      (out_carry == out_result[0] && out_overflow == (out_result[0] ^ out_result[BYTE_W-1]))); // R3
  AST_ZERO_CNT_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    acc && in_count == '0 |=> !out_flags_valid); // R6
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_flags_valid || (out_carry == $past(in_carry) && !out_overflow)); // R8
  AST_PASS_DWORD: assert property (@(posedge clk) disable iff (rst)
    acc && in_op == 2'd3 && in_size == 2'd2 |=> out_result == $past(in_operand) && !out_flags_valid); // R7
endmodule

// File: tb/rotflag_unit_tb.sv
module rotflag_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic [4:0]  in_count = '0;
  logic [1:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_carry, out_overflow, out_flags_valid;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  rotflag_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_op(in_op),
    .in_size(in_size), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry),
    .out_overflow(out_overflow), .out_flags_valid(out_flags_valid)
  );

  function automatic logic [31:0] pick(int i);
    case (i)
      0: return 32'h1234_5681;
      1: return 32'hC0DE_7F40;
      2: return 32'h0000_00C3;
      3: return 32'h8000_4001;
      4: return 32'h5A5A_A55A;
      5: return 32'hFFFF_FFFF;
      6: return 32'h0000_0000;
      default: return 32'h6B3E_91C2;
    endcase
  endfunction

  function automatic logic [34:0] model(logic [1:0] sz, logic [1:0] op,
                                        logic [4:0] c, logic ci, logic [31:0] a);
    int w, k, j;
    logic [31:0] am, r;
    logic fcf, fof, fv;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    am = '0;
    for (int i = 0; i < w; i++) am[i] = a[i];
    r = am; fv = 0; fcf = 0; fof = 0;
    case (op)
      2'd0: begin
        k = int'(c) % w;
        for (int i = 0; i < w; i++) r[i] = am[(i - k + w) % w];
        fv  = (k != 0) || (w < 32 && int'(c) >= w);
        fcf = r[0];
        fof = r[0] ^ r[w-1];
      end
      2'd1: begin
        k = int'(c) % w;
        for (int i = 0; i < w; i++) r[i] = am[(i + k) % w];
        fv  = (k != 0) || (w < 32 && int'(c) >= 16);
        fcf = r[w-1];
        fof = r[w-1] ^ r[w-2];
      end
      2'd2: begin
        k = int'(c) % (w + 1);
        if (k != 0) begin
          for (int i = 0; i < w; i++) begin
            j = (i + k) % (w + 1);
            r[i] = (j == w) ? ci : am[j];
          end
          fv  = 1;
          fcf = am[k-1];
          fof = r[w-1] ^ r[w-2];
        end
      end
      default: fv = 0;
    endcase
    if (!fv) begin
      fcf = ci;
      fof = 1'b0;
    end
    return {fv, fof, fcf, r};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (size %0d op %0d count %0d carry %0d operand %h)",
               tag, what, act, exp, in_size, in_op, in_count, in_carry, in_operand);
    end
  endtask

  task automatic check_out(logic [1:0] sz, logic [1:0] op, logic [4:0] c, logic ci, logic [31:0] a);
    logic [34:0] e;
    string t;
    int w;
    e = model(sz, op, c, ci, a);
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    t = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R4" : (op == 2'd2) ? "R5" : "R7";
    check("R2", "out_valid", 32'(out_valid), 32'd1);
    check(t, "result", out_result, e[31:0]);
    if (w < 32) check("R1", "upper bits", out_result >> w, 32'd0);
    check((op == 2'd0 || op == 2'd1) ? "R6" : t, "flags_valid", 32'(out_flags_valid), 32'(e[34]));
    check(e[34] ? t : "R8", "carry", 32'(out_carry), 32'(e[32]));
    check(e[34] ? t : "R8", "overflow", 32'(out_overflow), 32'(e[33]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "out_valid after reset", 32'(out_valid), 32'd0);
    check("R9", "in_ready after reset", 32'(in_ready), 32'd1);

    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 4; op++)
        for (int c = 0; c < 32; c++)
          for (int ci = 0; ci < 2; ci++)
            for (int v = 0; v < 8; v++) begin
              @(negedge clk);
              in_size = 2'(sz); in_op = 2'(op); in_count = 5'(c);
              in_carry = ci[0]; in_operand = pick(v);
              in_valid = 1'b1; out_ready = 1'b1;
              @(negedge clk);
              in_valid = 1'b0;
              check_out(2'(sz), 2'(op), 5'(c), ci[0], pick(v));
            end

    // Stall: R2
    @(negedge clk);
    out_ready = 1'b0;
    in_size = 2'd0; in_op = 2'd1; in_count = 5'd16; in_carry = 1'b0;
    in_operand = 32'h0000_0081; in_valid = 1'b1;
    @(negedge clk);
    check("R2", "in_ready while stalled", 32'(in_ready), 32'd0);
    in_op = 2'd0; in_count = 5'd3; in_operand = 32'h0000_0011;
    repeat (3) @(negedge clk);
    in_size = 2'd0; in_op = 2'd1; in_count = 5'd16; in_operand = 32'h0000_0081;
    check_out(2'd0, 2'd1, 5'd16, 1'b0, 32'h0000_0081);
    check("R2", "in_ready still stalled", 32'(in_ready), 32'd0);
    in_op = 2'd0; in_count = 5'd3; in_operand = 32'h0000_0011;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(2'd0, 2'd0, 5'd3, 1'b0, 32'h0000_0011);
    check("R2", "result after release", out_result, 32'h0000_0088);
    @(negedge clk);
    check("R2", "out_valid after drain", 32'(out_valid), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule